// File: doc/BRIEF.md
# Parallel Chien Search with Minimal-Polynomial Networks

This block finds the roots of a binary BCH error-locator polynomial over GF(2^M). A decoder hands it the coefficients Λ1..ΛT together with a one-cycle start pulse. The block then sweeps every code position from the highest (N−1) down to 0, testing P consecutive positions per clock. For each clock it presents a P-bit vector of error flags, and it raises a done pulse with the final vector.

The block contains no constant Galois-field multipliers. Each coefficient Λj first passes through a fixed binary matrix. That matrix re-expresses Λj as a polynomial Tj(x) in the powers of α^j, with a pre-rotation folded in for shortened codes. Advancing a position by one is then a single step of an unrolled linear-feedback network whose taps are the minimal polynomial of α^j. A grid of P by T such networks produces P positions at once. The remainder from the last row is registered for the next clock. Each row's T remainders are merged by exponent and mapped back to the standard basis by one shared matrix, which yields a zero test of Λ(x). The minimal polynomials and all matrices are derived at elaboration from the primitive polynomial given as a parameter.

Top module: `chien_mp_search`

## Requirements
- R1: After reset, busy, flag_valid, done and all err_flags bits are 0.
- R2: A start pulse sampled while busy is 0 captures lambda, where Λj sits in bits [j·M−1:(j−1)·M]. busy is high from the next cycle. flag_valid first rises one cycle after busy rises, and that first vector belongs to step τ=0.
- R3: A search yields exactly ceil(N/P) consecutive cycles with flag_valid high. done is high only together with the last of them, and busy is already low in that cycle.
- R4: In the valid cycle of step τ (counting from 0), flag bit b (0..P−1) stands for position L = N − P·(τ+1) + b. So bit P−1 is the highest position of the step, and the first step covers N−1 down to N−P. The bit is 1 exactly when L ≥ 0 and Λ(α^−L) = 0, with Λ(x) = 1 + Σ Λj·x^j. Field elements are in the standard basis (bit k is the coefficient of α^k), and the default field uses α^4 = α + 1.
- R5: err_flags is all zero in every cycle where flag_valid is low.
- R6: A start pulse while busy is high is ignored. The running search keeps its flags, its length and its done timing, and no new search follows it.
- R7: An all-zero lambda flags no position. A start pulse in the same cycle as done begins a new search right away.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a search |
| lambda | input | T*M | Locator coefficients Λ1..ΛT, Λ1 in the low bits |
| busy | output | 1 | A search is in progress |
| flag_valid | output | 1 | err_flags holds the vector of the current step |
| err_flags | output | P | Per-position root flags, bit P−1 = highest position of the step |
| done | output | 1 | High with the last valid vector of a search |

## Verification
The assertions assume that the locator's degree fits in T and that every α^j with j ≤ T has a minimal polynomial of full degree M. The basis change is only defined under that condition, and the default field satisfies it. They also assume that start is a single-cycle pulse whose lambda is stable in that cycle. The stimulus builds lambda either as a product of chosen linear root factors or from a fixed-seed random source, drives start and lambda only at falling edges, and issues extra starts only at chosen points inside or at the end of a search.

// File: rtl/chien_pkg.sv
package chien_pkg;

    typedef logic [15:0] gfw_t;

    // alpha^e in the standard basis of GF(2^m), m <= 16
    function automatic gfw_t alpha_pow(input int e, input int m, input logic [16:0] prim);
        gfw_t v;
        int   q;
        int   n;
        logic top;
        q = (1 << m) - 1;
        n = e % q;
        v = 16'd1;
        for (int i = 0; i < n; i++) begin
            top = v[m-1];
            v   = v << 1;
            if (top) v = v ^ prim[15:0];
            v = v & gfw_t'(q);
        end
        return v;
    endfunction

    // Solve A*c = target where column k of A is alpha^(j*k):
    // expresses target in the basis {1, alpha^j, ..., alpha^((m-1)j)}.
    function automatic gfw_t basis_solve(input int j, input gfw_t target, input int m,
                                         input logic [16:0] prim);
        logic [15:0][15:0] a;
        logic [15:0]       trow;
        gfw_t              rhs;
        gfw_t              col;
        int                piv;
        logic              tb;
        a   = '0;
        rhs = target;
        for (int k = 0; k < m; k++) begin
            col = alpha_pow(j * k, m, prim);
            for (int r = 0; r < m; r++) a[r][k] = col[r];
        end
        for (int c = 0; c < m; c++) begin
            piv = -1;
            for (int r = c; r < m; r++) if (piv < 0 && a[r][c]) piv = r;
            if (piv >= 0) begin
                trow = a[c]; a[c] = a[piv]; a[piv] = trow;
                tb = rhs[c]; rhs[c] = rhs[piv]; rhs[piv] = tb;
                for (int r = 0; r < m; r++) begin
                    if (r != c && a[r][c]) begin
                        a[r]   = a[r] ^ a[c];
                        rhs[r] = rhs[r] ^ rhs[c];
                    end
                end
            end
        end
        return rhs;
    endfunction

endpackage

// File: rtl/chien_ibt.sv
module chien_ibt
    import chien_pkg::*;
#(
    parameter int          M    = 4,
    parameter int          J    = 1,
    parameter int          SH   = 0,
    parameter logic [16:0] PRIM = 17'h13
) (
    input  logic [M-1:0] lam_j,
    output logic [M-1:0] coef_j
);
    logic [M-1:0] terms [M];

    // column q: image of alpha^q, pre-rotated by alpha^(J*SH), in the alpha^J basis
    for (genvar q = 0; q < M; q++) begin : g_col
        localparam gfw_t COL = basis_solve(J, alpha_pow(J * SH + q, M, PRIM), M, PRIM);
        assign terms[q] = lam_j[q] ? COL[M-1:0] : '0;
    end

    always_comb begin
        coef_j = '0;
        for (int q = 0; q < M; q++) coef_j = coef_j ^ terms[q];
    end
endmodule

// File: rtl/chien_mpcn.sv
module chien_mpcn #(
    parameter int           M    = 4,
    parameter logic [M-1:0] TAPS = '0
) (
    input  logic [M-1:0] d_in,
    output logic [M-1:0] d_out
);
    // one unrolled LFSR step: x*d(x) mod Mj(x), x^M folded back through TAPS
    assign d_out = {d_in[M-2:0], 1'b0} ^ (d_in[M-1] ? TAPS : '0);
endmodule

// File: rtl/chien_gbt.sv
module chien_gbt
    import chien_pkg::*;
#(
    parameter int          M    = 4,
    parameter int          T    = 2,
    parameter logic [16:0] PRIM = 17'h13
) (
    input  logic [T-1:0][M-1:0] rem,
    output logic                is_root
);
    localparam int VW = (M - 1) * T + 1;

    logic [VW-1:0] merged;
    logic [M-1:0]  terms [VW];
    logic [M-1:0]  acc;

    // combine remainder bits by the exponent (j*k) they stand for
    always_comb begin
        merged = '0;
        for (int j = 0; j < T; j++) begin
            for (int k = 0; k < M; k++) begin
                merged[(j + 1) * k] = merged[(j + 1) * k] ^ rem[j][k];
            end
        end
    end

    for (genvar v = 0; v < VW; v++) begin : g_exp
        localparam gfw_t PV = alpha_pow(v, M, PRIM);
        assign terms[v] = merged[v] ? PV[M-1:0] : '0;
    end

    always_comb begin
        acc    = '0;
        acc[0] = 1'b1;
        for (int v = 0; v < VW; v++) acc = acc ^ terms[v];
        is_root = (acc == '0);
    end
endmodule

// File: rtl/chien_mp_search.sv
module chien_mp_search
    import chien_pkg::*;
#(
    parameter int          M    = 4,
    parameter int          N    = 15,
    parameter int          T    = 2,
    parameter int          P    = 3,
    parameter logic [16:0] PRIM = 17'h13
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [T*M-1:0] lambda,
    output logic           busy,
    output logic           flag_valid,
    output logic [P-1:0]   err_flags,
    output logic           done
);
    localparam int Q  = (1 << M) - 1;
    localparam int SH = Q - N;
    localparam int NC = (N + P - 1) / P;
    localparam int TW = (NC > 1) ? $clog2(NC) : 1;
    localparam logic [TW-1:0] LAST = TW'(NC - 1);

    typedef struct packed {
        logic                busy;
        logic [TW-1:0]       tau;
        logic [T-1:0][M-1:0] lam;
        logic [T-1:0][M-1:0] st;
        logic [P-1:0]        flags;
        logic                valid;
        logic                done;
    } state_t;

    state_t s_q, s_d;

    logic [T-1:0][M-1:0]      init_c;
    logic [T-1:0][M-1:0]      base_c;
    logic [P:0][T-1:0][M-1:0] grid;
    logic [P-1:0]             root_c;
    logic [P-1:0]             hit_c;

    for (genvar j = 0; j < T; j++) begin : g_col
        localparam gfw_t TAPS = basis_solve(j + 1, alpha_pow((j + 1) * M, M, PRIM), M, PRIM);

        chien_ibt #(.M(M), .J(j + 1), .SH(SH), .PRIM(PRIM)) u_ibt (
            .lam_j (s_q.lam[j]),
            .coef_j(init_c[j])
        );

        // first step takes the transformed coefficient, later steps the stored remainder
        assign base_c[j]  = (s_q.tau == '0) ? init_c[j] : s_q.st[j];
        assign grid[0][j] = base_c[j];

        for (genvar r = 1; r <= P; r++) begin : g_row
            chien_mpcn #(.M(M), .TAPS(TAPS[M-1:0])) u_mpcn (
                .d_in (grid[r-1][j]),
                .d_out(grid[r][j])
            );
        end
    end

    for (genvar r = 1; r <= P; r++) begin : g_test
        chien_gbt #(.M(M), .T(T), .PRIM(PRIM)) u_gbt (
            .rem    (grid[r]),
            .is_root(root_c[r-1])
        );
    end

    // row r tests the position N - r - P*tau, which is flag bit P - r
    always_comb begin
        for (int b = 0; b < P; b++) begin
            hit_c[b] = root_c[P-1-b] && ((P * (int'(s_q.tau) + 1) - b) <= N);
        end
    end

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        s_d.done  = 1'b0;
        s_d.flags = '0;
        if (!s_q.busy) begin
            if (start) begin
                s_d.busy = 1'b1;
                s_d.tau  = '0;
                s_d.lam  = lambda;
            end
        end else begin
            s_d.valid = 1'b1;
            s_d.flags = hit_c;
            s_d.st    = grid[P];
            if (s_q.tau == LAST) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
                s_d.tau  = '0;
            end else begin
                s_d.tau = s_q.tau + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy       = s_q.busy;
    assign flag_valid = s_q.valid;
    assign err_flags  = s_q.flags;
    assign done       = s_q.done;

    // length of the current run of valid cycles, for the run-length check
    logic [15:0] vrun_q;
    always_ff @(posedge clk) begin
        if (!rst_n)          vrun_q <= '0;
        else if (s_q.valid)  vrun_q <= vrun_q + 16'd1;
        else                 vrun_q <= '0;
    end

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    // R2
    first_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> flag_valid);
    // R3
    run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (vrun_q == 16'(NC - 1)));
    // R3
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flag_valid && !busy));
    // R3
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_valid |-> (vrun_q < 16'(NC)));
    // R5
    quiet_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_valid |-> (err_flags == '0));
    // R6
    hold_coeff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(s_q.lam));
endmodule

// File: tb/chien_mp_search_tb.sv
`timescale 1ns/1ps
module chien_mp_search_tb_top;
    localparam int M  = 4;
    localparam int N  = 15;
    localparam int T  = 2;
    localparam int P  = 3;
    localparam int NC = (N + P - 1) / P;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [T*M-1:0] lambda = '0;
    logic           busy, flag_valid, done;
    logic [P-1:0]   err_flags;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    chien_mp_search #(.M(M), .N(N), .T(T), .P(P), .PRIM(17'h13)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .lambda(lambda),
        .busy(busy), .flag_valid(flag_valid), .err_flags(err_flags), .done(done)
    );

    function automatic logic [3:0] gf_mul(input logic [3:0] a, input logic [3:0] b);
        logic [3:0] r = 4'd0;
        logic [3:0] x = a;
        for (int i = 0; i < 4; i++) begin
            if (b[i]) r = r ^ x;
            x = x[3] ? ((x << 1) ^ 4'h3) : (x << 1);
        end
        return r;
    endfunction

    function automatic logic [3:0] gf_pow(input int e);
        logic [3:0] v = 4'd1;
        for (int i = 0; i < (e % 15); i++) v = gf_mul(v, 4'd2);
        return v;
    endfunction

    function automatic logic [3:0] lam_eval(input logic [T*M-1:0] lam, input logic [3:0] x);
        logic [3:0] acc = 4'd1;
        logic [3:0] xp  = 4'd1;
        for (int j = 0; j < T; j++) begin
            xp  = gf_mul(xp, x);
            acc = acc ^ gf_mul(lam[j*M +: M], xp);
        end
        return acc;
    endfunction

    function automatic logic [P-1:0] exp_flags(input logic [T*M-1:0] lam, input int tau);
        logic [P-1:0] f = '0;
        for (int b = 0; b < P; b++) begin
            int loc = N - P * (tau + 1) + b;
            if (loc >= 0 && lam_eval(lam, gf_pow((15 - loc) % 15)) == 4'd0) f[b] = 1'b1;
        end
        return f;
    endfunction

    // locator with roots at the two given positions (b < 0: single root)
    function automatic logic [T*M-1:0] two_roots(input int a, input int b);
        logic [T*M-1:0] l = '0;
        if (b < 0) begin
            l[3:0] = gf_pow(a);
        end else begin
            l[3:0] = gf_pow(a) ^ gf_pow(b);
            l[7:4] = gf_pow(a + b);
        end
        return l;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // caller stands at a falling edge; poke_at < NC-1 issues an ignored start
    task automatic run_search(input logic [T*M-1:0] lam, input int poke_at,
                              input logic [T*M-1:0] poke_lam, input bit chained);
        lambda = lam;
        start  = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2 busy after start", busy, 1);
        check(flag_valid == 1'b0, "R2 no vector in first busy cycle", flag_valid, 0);
        for (int tau = 0; tau < NC; tau++) begin
            @(negedge clk);
            start = 1'b0;
            check(flag_valid == 1'b1, "R3 valid run", flag_valid, 1);
            check(err_flags == exp_flags(lam, tau), "R4 flags", err_flags, exp_flags(lam, tau));
            check(done == (tau == NC - 1), "R3 done timing", done, (tau == NC - 1));
            if (tau == NC - 1)
                check(busy == 1'b0, "R3 idle at done", busy, 0);
            if (tau == poke_at) begin
                lambda = poke_lam;
                start  = 1'b1;
            end
        end
        if (!chained) begin
            @(negedge clk);
            check(flag_valid == 1'b0, "R3 run ended", flag_valid, 0);
            check(err_flags == '0, "R5 quiet flags", err_flags, 0);
            check(busy == 1'b0, "R6 no restart", busy, 0);
        end
    endtask

    initial begin
        #(20 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(flag_valid == 1'b0, "R1 valid", flag_valid, 0);
        check(done == 1'b0, "R1 done", done, 0);
        check(err_flags == '0, "R1 flags", err_flags, 0);

        // R4 corner positions: top and bottom of the sweep
        run_search(two_roots(0, 14), -1, '0, 1'b0);
        run_search(two_roots(13, 12), -1, '0, 1'b0);
        run_search(two_roots(1, 2), -1, '0, 1'b0);
        run_search(two_roots(7, -1), -1, '0, 1'b0);
        // R7 zero locator flags nothing
        run_search('0, -1, '0, 1'b0);
        // R6 start during a search is ignored
        run_search(two_roots(5, 9), 1, two_roots(3, 4), 1'b0);
        run_search(two_roots(10, 0), 0, 8'hff, 1'b0);
        // R7 back-to-back: start in the done cycle
        run_search(two_roots(6, 11), -1, '0, 1'b1);
        run_search(two_roots(2, 8), -1, '0, 1'b0);

        for (int k = 0; k < 24; k++) begin
            logic [T*M-1:0] lam;
            if (k % 2 == 0) lam = T*M'($urandom());
            else            lam = two_roots(int'($urandom() % 15), int'($urandom() % 15));
            run_search(lam, (k % 5 == 0) ? 2 : -1, T*M'($urandom()), 1'b0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule